// File: doc/BRIEF.md
# UDP Port Stream Demultiplexer

This block sits on the receive side of an Ethernet datapath. Frames arrive on one valid/ready beat stream. Each whole frame goes either to one of several streaming offload outputs or to a default control output, which leads to the processor that handles all other traffic. The choice depends on the UDP destination port carried in the frame header.

A small table of stream entries drives the choice. It is written and read over a simple memory-mapped register port. Each entry is one word holding an enable flag and a 16-bit port number. The block holds the leading beats of a frame until the destination port has arrived, picks the output, and then replays the held beats. It forwards the rest of the frame straight through with backpressure from the chosen output. The table is sampled when the first beat of a frame is accepted, so software may rewrite it at any time without splitting a frame.

Frames are presented most-significant byte first: frame byte 0 is in the top byte lane of beat 0. The header is assumed to be untagged Ethernet followed by IPv4.

Top module: `udp_port_demux`

## Requirements
- R1: After reset every entry reads as zero (disabled), so every frame leaves on the control output.
- R2: Entry i is the register word at address i. Bit 16 is the enable and bits [15:0] are the UDP port number. Bits [31:17] ignore writes and read as zero. Read data appears on the cycle after the read strobe.
- R3: A write to an address at or above the number of entries changes nothing, and a read there returns zero.
- R4: A frame counts as UDP when bytes 12..13 are 0x0800, byte 14 is 0x45 and byte 23 is 17. Its destination port is bytes 36..37, big-endian. A UDP frame whose port equals the port of an enabled entry leaves entirely on that entry's stream output. This includes a frame that ends exactly on the beat carrying byte 37.
- R5: Every other frame leaves on the control output. This covers an unmatched port, a match only on a disabled entry, a wrong EtherType, a protocol other than UDP, a header length byte other than 0x45, and a frame that ends before byte 37.
- R6: When several enabled entries hold the same matching port, the lowest-numbered entry wins.
- R7: Every beat's data and end-of-frame flag reach the chosen output unchanged and in order, with none dropped or added.
- R8: At most one output shows valid in any cycle, and only the output chosen for the current frame does.
- R9: While the chosen output withholds ready, its beat stays valid and unchanged. Once the header beats are held, the input withholds ready; for 32-bit beats this happens after exactly ten beats.
- R10: Entry changes made after the first beat of a frame is accepted do not affect that frame. They apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mm_addr | input | MM_ADDR_W | Register word address |
| mm_wr | input | 1 | Register write strobe |
| mm_wdata | input | 32 | Register write data |
| mm_rd | input | 1 | Register read strobe |
| mm_rdata | output | 32 | Register read data, one cycle after strobe |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | DATA_W | Input beat data |
| in_last | input | 1 | Input beat ends the frame |
| ctl_valid | output | 1 | Control output beat valid |
| ctl_ready | input | 1 | Control output ready |
| ctl_data | output | DATA_W | Control output data |
| ctl_last | output | 1 | Control output end of frame |
| st_valid | output | N_STREAMS | Per-stream beat valid |
| st_ready | input | N_STREAMS | Per-stream ready |
| st_data | output | N_STREAMS*DATA_W | Per-stream data, stream i at bits [i*DATA_W +: DATA_W] |
| st_last | output | N_STREAMS | Per-stream end of frame |

## Verification
The bench uses the default build: 32-bit beats, four entries and a three-bit register address. With these values the header spans ten beats and the port field lands in the final held beat, so a ten-beat frame tests the boundary and a nine-beat frame tests the short case. Four entries leave room for duplicate ports to exercise priority, and addresses four to seven test the out-of-range rules. Random frame lengths, kinds, ports, ready patterns and table rewrites are mixed with directed stall, mid-frame rewrite and priority cases.

// File: rtl/udp_demux_pkg.sv
package udp_demux_pkg;

   localparam int MM_DATA_W = 32;
   localparam int PORT_W    = 16;
   localparam int ENTRY_W   = PORT_W + 1;

   // header byte offsets within a frame (byte 0 first on the wire)
   localparam int OFS_ETYPE  = 12;
   localparam int OFS_VIHL   = 14;
   localparam int OFS_PROTO  = 23;
   localparam int OFS_DPORT  = 36;
   localparam int LAST_HDR_B = OFS_DPORT + 1;

   localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
   localparam logic [7:0]  VIHL_PLAIN = 8'h45;
   localparam logic [7:0]  PROTO_UDP  = 8'd17;

   typedef struct packed {
      logic              en;
      logic [PORT_W-1:0] port;
   } entry_t;

   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_DRAIN   = 2'd1,
      ST_PASS    = 2'd2
   } fsm_t;

endpackage

// File: rtl/udp_demux_regs.sv
module udp_demux_regs
   import udp_demux_pkg::*;
#(
   parameter int N_STREAMS = 4,
   parameter int MM_ADDR_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [MM_ADDR_W-1:0]          mm_addr,
   input  logic                          mm_wr,
   input  logic [MM_DATA_W-1:0]          mm_wdata,
   input  logic                          mm_rd,
   output logic [MM_DATA_W-1:0]          mm_rdata,
   output entry_t [N_STREAMS-1:0]        entries
);

   localparam int PAD_W = MM_DATA_W - ENTRY_W;

   entry_t rd_word;

   for (genvar i = 0; i < N_STREAMS; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            entries[i] <= '0;
         end else if (mm_wr && mm_addr == MM_ADDR_W'(i)) begin
            entries[i].en   <= mm_wdata[PORT_W];
            entries[i].port <= mm_wdata[PORT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N_STREAMS; i++) begin
         if (mm_addr == MM_ADDR_W'(i)) rd_word = entries[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_rdata <= '0;
      end else if (mm_rd) begin
         mm_rdata <= {{PAD_W{1'b0}}, rd_word};
      end
   end

endmodule

// File: rtl/udp_demux_hold.sv
module udp_demux_hold #(
   parameter int DATA_W    = 32,
   parameter int HDR_BEATS = 10,
   parameter int IDX_W     = $clog2(HDR_BEATS + 1)
) (
   input  logic                          clk,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          wr_last,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_data,
   output logic                          rd_last,
   output logic [HDR_BEATS*DATA_W-1:0]   hdr_flat
);

   localparam int HDR_BITS = HDR_BEATS * DATA_W;

   logic [DATA_W-1:0] mem_d [HDR_BEATS];
   logic              mem_l [HDR_BEATS];

   always_ff @(posedge clk) begin
      for (int b = 0; b < HDR_BEATS; b++) begin
         if (wr_en && wr_idx == IDX_W'(b)) begin
            mem_d[b] <= wr_data;
            mem_l[b] <= wr_last;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      rd_last = 1'b0;
      for (int b = 0; b < HDR_BEATS; b++) begin
         if (rd_idx == IDX_W'(b)) begin
            rd_data = mem_d[b];
            rd_last = mem_l[b];
         end
      end
   end

   // header view: stored beats with the beat being written laid over
   for (genvar b = 0; b < HDR_BEATS; b++) begin : g_view
      assign hdr_flat[HDR_BITS-1-b*DATA_W -: DATA_W] =
         (wr_en && wr_idx == IDX_W'(b)) ? wr_data : mem_d[b];
   end

endmodule

// File: rtl/udp_demux_match.sv
module udp_demux_match
   import udp_demux_pkg::*;
#(
   parameter int N_STREAMS = 4,
   parameter int HDR_BITS  = 320,
   parameter int SEL_W     = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
   input  logic [HDR_BITS-1:0]     hdr_flat,
   input  logic                    hdr_complete,
   input  entry_t [N_STREAMS-1:0]  entries,
   output logic                    hit,
   output logic [SEL_W-1:0]        hit_idx
);

   function automatic logic [7:0] hbyte(input logic [HDR_BITS-1:0] f, input int k);
      return f[HDR_BITS-1-8*k -: 8];
   endfunction

   logic [15:0]          etype;
   logic [7:0]           vihl;
   logic [7:0]           proto;
   logic [PORT_W-1:0]    dport;
   logic                 is_udp;
   logic [N_STREAMS-1:0] hits;

   assign etype  = {hbyte(hdr_flat, OFS_ETYPE), hbyte(hdr_flat, OFS_ETYPE + 1)};
   assign vihl   = hbyte(hdr_flat, OFS_VIHL);
   assign proto  = hbyte(hdr_flat, OFS_PROTO);
   assign dport  = {hbyte(hdr_flat, OFS_DPORT), hbyte(hdr_flat, OFS_DPORT + 1)};
   assign is_udp = hdr_complete && (etype == ETYPE_IPV4) &&
                   (vihl == VIHL_PLAIN) && (proto == PROTO_UDP);

   for (genvar i = 0; i < N_STREAMS; i++) begin : g_cmp
      assign hits[i] = is_udp && entries[i].en && (entries[i].port == dport);
   end

   // lowest index wins: scan downward so the last assignment is the lowest
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = N_STREAMS - 1; i >= 0; i--) begin
         if (hits[i]) begin
            hit     = 1'b1;
            hit_idx = SEL_W'(i);
         end
      end
   end

endmodule

// File: rtl/udp_port_demux.sv
module udp_port_demux
   import udp_demux_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int N_STREAMS = 4,
   parameter int MM_ADDR_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [MM_ADDR_W-1:0]          mm_addr,
   input  logic                          mm_wr,
   input  logic [31:0]                   mm_wdata,
   input  logic                          mm_rd,
   output logic [31:0]                   mm_rdata,
   input  logic                          in_valid,
   output logic                          in_ready,
   input  logic [DATA_W-1:0]             in_data,
   input  logic                          in_last,
   output logic                          ctl_valid,
   input  logic                          ctl_ready,
   output logic [DATA_W-1:0]             ctl_data,
   output logic                          ctl_last,
   output logic [N_STREAMS-1:0]          st_valid,
   input  logic [N_STREAMS-1:0]          st_ready,
   output logic [N_STREAMS*DATA_W-1:0]   st_data,
   output logic [N_STREAMS-1:0]          st_last
);

   localparam int BYTES     = DATA_W / 8;
   localparam int DEC_IDX   = LAST_HDR_B / BYTES;
   localparam int HDR_BEATS = DEC_IDX + 1;
   localparam int HDR_BITS  = HDR_BEATS * DATA_W;
   localparam int IDX_W     = $clog2(HDR_BEATS + 1);
   localparam int SEL_W     = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("udp_port_demux: DATA_W must be a positive multiple of 8");
   end
   if (N_STREAMS < 1) begin : g_bad_count
      $error("udp_port_demux: N_STREAMS must be at least 1");
   end
   if ((1 << MM_ADDR_W) < N_STREAMS) begin : g_bad_addr
      $error("udp_port_demux: MM_ADDR_W too narrow for N_STREAMS entries");
   end

   entry_t [N_STREAMS-1:0] live_entries;
   entry_t [N_STREAMS-1:0] snap_entries;
   entry_t [N_STREAMS-1:0] use_entries;

   fsm_t               state;
   logic [IDX_W-1:0]   wr_idx;
   logic [IDX_W-1:0]   rd_idx;
   logic [IDX_W-1:0]   held_end;
   logic               ended;
   logic               sel_hit;
   logic [SEL_W-1:0]   sel_idx;

   logic               in_acc;
   logic               hold_wr;
   logic               hdr_complete;
   logic               decide;
   logic               hit;
   logic [SEL_W-1:0]   hit_idx;
   logic [DATA_W-1:0]  rd_data;
   logic               rd_last;
   logic [HDR_BITS-1:0] hdr_flat;
   logic               dst_ready;
   logic               out_valid;
   logic [DATA_W-1:0]  out_data;
   logic               out_last;

   udp_demux_regs #(
      .N_STREAMS (N_STREAMS),
      .MM_ADDR_W (MM_ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .mm_addr  (mm_addr),
      .mm_wr    (mm_wr),
      .mm_wdata (mm_wdata),
      .mm_rd    (mm_rd),
      .mm_rdata (mm_rdata),
      .entries  (live_entries)
   );

   udp_demux_hold #(
      .DATA_W    (DATA_W),
      .HDR_BEATS (HDR_BEATS),
      .IDX_W     (IDX_W)
   ) u_hold (
      .clk      (clk),
      .wr_en    (hold_wr),
      .wr_idx   (wr_idx),
      .wr_data  (in_data),
      .wr_last  (in_last),
      .rd_idx   (rd_idx),
      .rd_data  (rd_data),
      .rd_last  (rd_last),
      .hdr_flat (hdr_flat)
   );

   udp_demux_match #(
      .N_STREAMS (N_STREAMS),
      .HDR_BITS  (HDR_BITS),
      .SEL_W     (SEL_W)
   ) u_match (
      .hdr_flat     (hdr_flat),
      .hdr_complete (hdr_complete),
      .entries      (use_entries),
      .hit          (hit),
      .hit_idx      (hit_idx)
   );

   // the table is sampled with the first beat; later beats use the snapshot
   assign use_entries  = (wr_idx == '0) ? live_entries : snap_entries;
   assign in_acc       = in_valid && in_ready;
   assign hold_wr      = in_acc && (state == ST_COLLECT);
   assign hdr_complete = (wr_idx == IDX_W'(DEC_IDX));
   assign decide       = hold_wr && (in_last || hdr_complete);

   always_comb begin
      dst_ready = ctl_ready;
      if (sel_hit) begin
         for (int i = 0; i < N_STREAMS; i++) begin
            if (sel_idx == SEL_W'(i)) dst_ready = st_ready[i];
         end
      end
   end

   always_comb begin
      case (state)
         ST_COLLECT: begin
            in_ready  = 1'b1;
            out_valid = 1'b0;
            out_data  = rd_data;
            out_last  = rd_last;
         end
         ST_DRAIN: begin
            in_ready  = 1'b0;
            out_valid = 1'b1;
            out_data  = rd_data;
            out_last  = rd_last;
         end
         ST_PASS: begin
            in_ready  = dst_ready;
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = in_last;
         end
         default: begin
            in_ready  = 1'b0;
            out_valid = 1'b0;
            out_data  = rd_data;
            out_last  = rd_last;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state        <= ST_COLLECT;
         wr_idx       <= '0;
         rd_idx       <= '0;
         held_end     <= '0;
         ended        <= 1'b0;
         sel_hit      <= 1'b0;
         sel_idx      <= '0;
         snap_entries <= '0;
      end else begin
         case (state)
            ST_COLLECT: begin
               if (hold_wr && wr_idx == '0) snap_entries <= live_entries;
               if (decide) begin
                  sel_hit  <= hit;
                  sel_idx  <= hit_idx;
                  held_end <= wr_idx;
                  ended    <= in_last;
                  rd_idx   <= '0;
                  wr_idx   <= '0;
                  state    <= ST_DRAIN;
               end else if (hold_wr) begin
                  wr_idx <= wr_idx + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (dst_ready) begin
                  if (rd_idx == held_end) begin
                     state <= ended ? ST_COLLECT : ST_PASS;
                  end else begin
                     rd_idx <= rd_idx + 1'b1;
                  end
               end
            end
            ST_PASS: begin
               if (in_acc && in_last) state <= ST_COLLECT;
            end
            default: state <= ST_COLLECT;
         endcase
      end
   end

   assign ctl_valid = out_valid && !sel_hit;
   assign ctl_data  = out_data;
   assign ctl_last  = out_last;

   for (genvar i = 0; i < N_STREAMS; i++) begin : g_out
      assign st_valid[i]                 = out_valid && sel_hit && (sel_idx == SEL_W'(i));
      assign st_data[i*DATA_W +: DATA_W] = out_data;
      assign st_last[i]                  = out_last;
   end

endmodule

// File: rtl/udp_port_demux_chk.sv
module udp_port_demux_chk #(
   parameter int DATA_W    = 32,
   parameter int N_STREAMS = 4,
   parameter int MM_ADDR_W = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [MM_ADDR_W-1:0]          mm_addr,
   input logic                          mm_rd,
   input logic [31:0]                   mm_rdata,
   input logic                          ctl_valid,
   input logic                          ctl_ready,
   input logic [DATA_W-1:0]             ctl_data,
   input logic                          ctl_last,
   input logic [N_STREAMS-1:0]          st_valid,
   input logic [N_STREAMS-1:0]          st_ready,
   input logic [N_STREAMS*DATA_W-1:0]   st_data,
   input logic [N_STREAMS-1:0]          st_last
);

   AST_ONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctl_valid, st_valid})) else $error("two outputs valid"); // R8

   AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_last)))
      else $error("control beat changed under backpressure"); // R9

   for (genvar i = 0; i < N_STREAMS; i++) begin : g_st
      AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (st_valid[i] && !st_ready[i]) |=>
         (st_valid[i] && $stable(st_data[i*DATA_W +: DATA_W]) && $stable(st_last[i])))
         else $error("stream beat changed under backpressure"); // R9
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mm_rdata[31:17] == '0) else $error("reserved read bits set"); // R2

   AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_rd && int'(mm_addr) >= N_STREAMS) |=> (mm_rdata == '0))
      else $error("out-of-range read not zero"); // R3

endmodule

bind udp_port_demux udp_port_demux_chk #(
   .DATA_W    (DATA_W),
   .N_STREAMS (N_STREAMS),
   .MM_ADDR_W (MM_ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mm_addr   (mm_addr),
   .mm_rd     (mm_rd),
   .mm_rdata  (mm_rdata),
   .ctl_valid (ctl_valid),
   .ctl_ready (ctl_ready),
   .ctl_data  (ctl_data),
   .ctl_last  (ctl_last),
   .st_valid  (st_valid),
   .st_ready  (st_ready),
   .st_data   (st_data),
   .st_last   (st_last)
);

// File: tb/udp_port_demux_bench.sv
`timescale 1ns/1ps
module udp_port_demux_bench;

   localparam int DW  = 32;
   localparam int NS  = 4;
   localparam int AW  = 3;
   localparam int CTL = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   mm_addr = '0;
   logic            mm_wr = 1'b0;
   logic [31:0]     mm_wdata = '0;
   logic            mm_rd = 1'b0;
   logic [31:0]     mm_rdata;
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [DW-1:0]   in_data = '0;
   logic            in_last = 1'b0;
   logic            ctl_valid;
   logic            ctl_ready = 1'b0;
   logic [DW-1:0]   ctl_data;
   logic            ctl_last;
   logic [NS-1:0]   st_valid;
   logic [NS-1:0]   st_ready = '0;
   logic [NS*DW-1:0] st_data;
   logic [NS-1:0]   st_last;

   always #2 clk = ~clk;

   udp_port_demux #(.DATA_W(DW), .N_STREAMS(NS), .MM_ADDR_W(AW)) u_udp_port_demux (
      .clk(clk), .rst_n(rst_n),
      .mm_addr(mm_addr), .mm_wr(mm_wr), .mm_wdata(mm_wdata), .mm_rd(mm_rd), .mm_rdata(mm_rdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_data(ctl_data), .ctl_last(ctl_last),
      .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_last(st_last)
   );

   int          nchk = 0;
   int          nerr = 0;
   bit          done = 1'b0;
   logic [16:0] shadow [NS];
   logic [7:0]  fbytes [256];
   logic [31:0] fb [64];
   int          flen = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // kind: 0 udp, 1 tcp, 2 arp ethertype, 3 header length 0x46
   task automatic build_frame(input int kind, input logic [15:0] dport, input int nbeats);
      for (int k = 0; k < 256; k++) fbytes[k] = 8'($urandom);
      fbytes[12] = 8'h08;
      fbytes[13] = (kind == 2) ? 8'h06 : 8'h00;
      fbytes[14] = (kind == 3) ? 8'h46 : 8'h45;
      fbytes[23] = (kind == 1) ? 8'd6 : 8'd17;
      fbytes[36] = dport[15:8];
      fbytes[37] = dport[7:0];
      flen = nbeats;
      for (int b = 0; b < nbeats; b++)
         fb[b] = {fbytes[4*b], fbytes[4*b+1], fbytes[4*b+2], fbytes[4*b+3]};
   endtask

   function automatic int exp_dest();
      logic [15:0] dp;
      if (flen < 10) return CTL;
      if (fbytes[12] != 8'h08 || fbytes[13] != 8'h00) return CTL;
      if (fbytes[14] != 8'h45 || fbytes[23] != 8'd17) return CTL;
      dp = {fbytes[36], fbytes[37]};
      for (int i = 0; i < NS; i++)
         if (shadow[i][16] && shadow[i][15:0] == dp) return i;
      return CTL;
   endfunction

   task automatic mm_write(input int addr, input logic [31:0] d);
      @(negedge clk);
      mm_wr = 1'b1; mm_addr = AW'(addr); mm_wdata = d;
      if (addr < NS) shadow[addr] = d[16:0];
      @(negedge clk);
      mm_wr = 1'b0;
   endtask

   task automatic mm_read(input int addr, output logic [31:0] d);
      @(negedge clk);
      mm_rd = 1'b1; mm_addr = AW'(addr);
      @(negedge clk);
      mm_rd = 1'b0;
      d = mm_rdata;
   endtask

   task automatic run_frame(input string tag, input int rpct, input int vpct, input int stall,
                            input int mid_a, input logic [31:0] mid_d);
      int exp, tx, rx, cyc, first, vc;
      bit bad, hold, pend;
      exp = exp_dest();
      tx = 0; rx = 0; cyc = 0; first = -1; bad = 0; hold = 0;
      pend = (mid_a >= 0);
      while (rx < flen && cyc < 4000) begin
         @(negedge clk);
         mm_wr = 1'b0;
         if (pend && tx >= 3) begin
            mm_wr = 1'b1; mm_addr = AW'(mid_a); mm_wdata = mid_d;
            shadow[mid_a] = mid_d[16:0];
            pend = 0;
         end
         if (stall > 0 && cyc == stall) check(tx == 10, "R9 header-only intake", tx, 10);
         if (!hold) begin
            in_valid = (tx < flen) && (($urandom % 100) < vpct);
            in_data  = fb[(tx < flen) ? tx : 0];
            in_last  = (tx == flen - 1);
         end
         if (cyc < stall) begin
            ctl_ready = 1'b0; st_ready = '0;
         end else begin
            ctl_ready = (($urandom % 100) < rpct);
            for (int i = 0; i < NS; i++) st_ready[i] = (($urandom % 100) < rpct);
         end
         #1;
         vc = 0;
         if (ctl_valid) begin
            vc++;
            if (first < 0) first = CTL;
            if (exp != CTL) bad = 1;
            if (ctl_ready) begin
               if (ctl_data != fb[rx] || ctl_last != (rx == flen - 1)) bad = 1;
               rx++;
            end
         end
         for (int i = 0; i < NS; i++) begin
            if (st_valid[i]) begin
               vc++;
               if (first < 0) first = i;
               if (exp != i) bad = 1;
               if (st_ready[i]) begin
                  if (st_data[i*DW +: DW] != fb[rx] || st_last[i] != (rx == flen - 1)) bad = 1;
                  rx++;
               end
            end
         end
         if (vc > 1) bad = 1;
         hold = in_valid && !in_ready;
         if (in_valid && in_ready) tx++;
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0; mm_wr = 1'b0;
      check(!bad && rx == flen && tx == flen, tag, first, exp);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [15:0] ports [4];
      void'($urandom(32'd20240611));
      for (int i = 0; i < NS; i++) shadow[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < NS; i++) begin
         mm_read(i, rd);
         check(rd == 0, "R1 entry after reset", rd, 0);
      end
      build_frame(0, 16'h1234, 14);
      run_frame("R1 all traffic to control", 100, 100, 0, -1, 0);

      // R2 field layout and reserved bits
      mm_write(0, 32'hFFFF_1234);
      mm_read(0, rd);
      check(rd == 32'h0001_1234, "R2 enabled entry readback", rd, 32'h0001_1234);
      mm_write(1, 32'h0000_5678);
      mm_read(1, rd);
      check(rd == 32'h0000_5678, "R2 disabled entry readback", rd, 32'h0000_5678);

      // R3 out-of-range address
      mm_write(6, 32'h0001_9999);
      mm_read(6, rd);
      check(rd == 0, "R3 out-of-range read", rd, 0);
      mm_read(2, rd);
      check(rd == 0, "R3 entry untouched", rd, 0);
      mm_read(0, rd);
      check(rd == 32'h0001_1234, "R3 entry0 untouched", rd, 32'h0001_1234);

      // R4 / R5 basic routing
      build_frame(0, 16'h1234, 20);
      run_frame("R4 match to stream 0", 100, 100, 0, -1, 0);
      build_frame(0, 16'h5678, 20);
      run_frame("R5 disabled entry to control", 100, 100, 0, -1, 0);

      // R6 priority
      mm_write(1, 32'h0001_5678);
      mm_write(2, 32'h0001_1234);
      mm_write(3, 32'h0001_0050);
      build_frame(0, 16'h1234, 16);
      run_frame("R6 lowest entry wins", 90, 90, 0, -1, 0);
      mm_write(0, 32'h0000_1234);
      build_frame(0, 16'h1234, 16);
      run_frame("R6 next entry wins", 90, 90, 0, -1, 0);

      // R5 non-UDP and short frames, R4 boundary
      build_frame(1, 16'h5678, 15);
      run_frame("R5 tcp to control", 100, 100, 0, -1, 0);
      build_frame(2, 16'h5678, 15);
      run_frame("R5 arp to control", 100, 100, 0, -1, 0);
      build_frame(3, 16'h5678, 15);
      run_frame("R5 header length to control", 100, 100, 0, -1, 0);
      build_frame(0, 16'h5678, 9);
      run_frame("R5 short frame to control", 100, 100, 0, -1, 0);
      build_frame(0, 16'h5678, 10);
      run_frame("R4 ten-beat boundary frame", 100, 100, 0, -1, 0);
      build_frame(0, 16'h5678, 1);
      run_frame("R5 one-beat frame", 100, 100, 0, -1, 0);

      // R10 mid-frame change
      build_frame(0, 16'h0050, 24);
      run_frame("R10 frame keeps old routing", 80, 100, 0, 3, 32'h0000_0050);
      build_frame(0, 16'h0050, 24);
      run_frame("R10 change applies next frame", 80, 100, 0, -1, 0);

      // R9 backpressure
      build_frame(0, 16'h1234, 20);
      run_frame("R9 stalled frame intact", 100, 100, 30, -1, 0);
      build_frame(0, 16'h5678, 20);
      run_frame("R9 heavy backpressure", 25, 70, 0, -1, 0);

      // R7 / R8 random traffic
      for (int n = 0; n < 60; n++) begin
         int kind;
         int len;
         logic [15:0] dp;
         ports[0] = 16'h1234; ports[1] = 16'h5678; ports[2] = 16'h0050; ports[3] = 16'($urandom);
         if (($urandom % 3) == 0)
            mm_write($urandom % NS, {15'($urandom), 1'($urandom), ports[$urandom % 3]});
         kind = $urandom % 6;
         dp = ports[$urandom % 4];
         len = (kind == 5) ? 1 + ($urandom % 9) : 10 + ($urandom % 30);
         build_frame((kind >= 4) ? 0 : kind, dp, len);
         run_frame("R7/R8 random frame", 60, 75, 0, -1, 0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule